// File: doc/BRIEF.md
# Bit-Serial Systematic BCH Sector Encoder

This block adds error-correction parity to one flash sector of 4096 data bits, one bit per clock. The code is a binary BCH code over GF(2^13) that corrects up to seven random bit errors. It is the length-8191 primitive, narrow-sense code cut down to 4187 bits, so the 91 parity bits fit inside the 128 spare bits that a sector reserves for redundancy. The top 4004 message coefficients of the full-length code are treated as zero and are never clocked. The spare 37 bits are not driven by this block.

The upstream source presents data bits with a valid strobe. The first bit of a sector carries a start marker. Each accepted data bit appears on the output in the same cycle, unchanged. At the same time a 91-stage division register accumulates the remainder of m(x)·x^91 divided by the generator polynomial. Once the 4096th bit is taken, the block stops accepting input for 91 cycles and shifts the remainder out. The last parity bit is flagged as the end of the codeword. The generator polynomial is fixed when the design is built. It is the product of the minimal polynomials of alpha, alpha^3, ..., alpha^13 in the field defined by x^13+x^4+x^3+x+1, and a package function computes it.

Top module: `bch_sector_enc`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, out_is_par and out_eob are 0 while no input is offered.
- R2: A data bit is accepted when in_valid and in_ready are both 1, and either in_sop is 1 or a sector is already in progress. In that same cycle out_valid is 1, out_is_par is 0 and out_bit equals in_bit.
- R3: After the 4096th data bit is accepted, the next 91 cycles each have out_valid=1 and out_is_par=1. Over those cycles, out_bit carries the coefficients of x^90 down to x^0 of the remainder of m(x)·x^91 divided by g(x), where the first data bit is the coefficient of x^4095.
- R4: The 4187-bit word formed by the 4096 data bits followed by the 91 parity bits, first bit as the coefficient of x^4186, is divisible by g(x).
- R5: in_ready is 0 in every parity cycle. Beats offered during parity, including ones with in_sop=1, are ignored and do not change the parity stream.
- R6: out_eob is 1 only together with the 91st parity bit of a sector.
- R7: With no sector in progress, beats that have in_valid=1 and in_sop=0 give no output and do not affect the parity of the next sector.
- R8: A beat with in_sop=1 during the data phase abandons the current sector. It clears the division register and becomes data bit 0 of a new sector.
- R9: Cycles with in_valid=0 in the data phase give out_valid=0 and do not change the resulting parity.
- R10: in_ready is 1 in the cycle right after the last parity bit, so a new sector may start there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is offered |
| in_sop | input | 1 | Offered bit is the first bit of a sector |
| in_bit | input | 1 | Data bit, highest-degree coefficient first |
| in_ready | output | 1 | Block accepts data; low during parity output |
| out_valid | output | 1 | out_bit carries a codeword bit |
| out_bit | output | 1 | Codeword bit (data pass-through or parity) |
| out_is_par | output | 1 | Current output bit is parity |
| out_eob | output | 1 | Current output bit is the last of the codeword |

## Verification
The hardest case to reach from the ports is a start marker landing on a busy state. One such case is a marker arriving in the middle of a sector. Another is a marker-carrying beat offered during parity output, combined with a new sector that starts in the very first cycle after the last parity bit. The stimulus covers these directly. It abandons a sector after a few hundred bits and restarts it at once. It keeps in_valid and in_sop toggling randomly through every parity window. Successive sectors run back to back with no idle gap. Every emitted word is also reduced modulo g(x) independently, so an error in a tap or in the bit order shows up as a nonzero remainder.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

    localparam int GF_M = 13;
    localparam int T_CORR = 7;
    localparam logic [GF_M:0] GF_POLY = 14'h201B;
    localparam int PAR_BITS = GF_M * T_CORR;
    localparam int MSG_BITS = 4096;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MSG  = 2'd1,
        PH_PAR  = 2'd2
    } phase_e;

    // Product of two field elements, reduced by the field polynomial.
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] acc;
        logic [GF_M-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[GF_M-1]) sh = (sh << 1) ^ GF_POLY[GF_M-1:0];
            else            sh = sh << 1;
        end
        return acc;
    endfunction

    // Generator: product of minimal polynomials of alpha^j, j odd, 1..2t-1.
    function automatic logic [PAR_BITS:0] bch_gen_poly();
        logic [PAR_BITS:0] gp;
        logic [PAR_BITS:0] prod;
        logic [GF_M:0][GF_M-1:0] mp;
        logic [GF_M:0] mb;
        logic [GF_M-1:0] beta;
        logic [GF_M-1:0] c;
        logic done;
        gp = '0;
        gp[0] = 1'b1;
        for (int j = 1; j < 2 * T_CORR; j += 2) begin
            beta = GF_M'(1);
            for (int k = 0; k < j; k++) beta = gf_mul(beta, GF_M'(2));
            mp = '0;
            mp[0] = GF_M'(1);
            c = beta;
            done = 1'b0;
            for (int k = 0; k < GF_M; k++) begin
                if (!done) begin
                    for (int i = GF_M; i >= 1; i--) mp[i] = mp[i-1] ^ gf_mul(c, mp[i]);
                    mp[0] = gf_mul(c, mp[0]);
                    c = gf_mul(c, c);
                    if (c == beta) done = 1'b1;
                end
            end
            for (int i = 0; i <= GF_M; i++) mb[i] = mp[i][0];
            prod = '0;
            for (int i = 0; i <= GF_M; i++) begin
                if (mb[i]) prod = prod ^ (gp << i);
            end
            gp = prod;
        end
        return gp;
    endfunction

    localparam logic [PAR_BITS:0] GEN_POLY = bch_gen_poly();

endpackage

// File: rtl/bch_blk_ctrl.sv
module bch_blk_ctrl
    import bch_enc_pkg::*;
#(
    parameter int MSG_N = 4096,
    parameter int PAR_N = 91
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    output logic in_ready,
    output logic take,
    output logic clear,
    output logic par_shift,
    output logic last_par
);

    localparam int MAX_N = (MSG_N > PAR_N) ? MSG_N : PAR_N;
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam logic [CNT_W-1:0] MSG_LAST = CNT_W'(MSG_N - 1);
    localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(PAR_N - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic [CNT_W-1:0] base_cnt;

    assign in_ready  = (st_q.phase != PH_PAR);
    assign take      = in_valid && in_ready && (in_sop || st_q.phase == PH_MSG);
    assign clear     = take && in_sop;
    assign par_shift = (st_q.phase == PH_PAR);
    assign last_par  = par_shift && (st_q.cnt == PAR_LAST);

    always_comb begin
        st_d = st_q;
        base_cnt = in_sop ? '0 : st_q.cnt;
        if (st_q.phase == PH_PAR) begin
            if (st_q.cnt == PAR_LAST) begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (take) begin
            if (base_cnt == MSG_LAST) begin
                st_d.phase = PH_PAR;
                st_d.cnt   = '0;
            end else begin
                st_d.phase = PH_MSG;
                st_d.cnt   = base_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bch_lfsr_div.sv
module bch_lfsr_div #(
    parameter int PAR_N = 91,
    parameter logic [PAR_N:0] GEN = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic clear,
    input  logic par_shift,
    input  logic in_bit,
    output logic par_msb
);

    localparam logic [PAR_N-1:0] TAPS = GEN[PAR_N-1:0];

    logic [PAR_N-1:0] rem_d, rem_q;
    logic [PAR_N-1:0] base;
    logic             fb;

    assign par_msb = rem_q[PAR_N-1];

    always_comb begin
        base  = clear ? '0 : rem_q;
        fb    = in_bit ^ base[PAR_N-1];
        rem_d = rem_q;
        if (take) begin
            rem_d = {base[PAR_N-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end else if (par_shift) begin
            rem_d = {rem_q[PAR_N-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

endmodule

// File: rtl/bch_out_mux.sv
module bch_out_mux (
    input  logic take,
    input  logic in_bit,
    input  logic par_shift,
    input  logic par_msb,
    input  logic last_par,
    output logic out_valid,
    output logic out_bit,
    output logic out_is_par,
    output logic out_eob
);

    always_comb begin
        out_valid  = take || par_shift;
        out_bit    = par_shift ? par_msb : (take && in_bit);
        out_is_par = par_shift;
        out_eob    = last_par;
    end

endmodule

// File: rtl/bch_sector_enc.sv
module bch_sector_enc
    import bch_enc_pkg::*;
#(
    parameter int MSG_N = bch_enc_pkg::MSG_BITS,
    parameter int PAR_N = bch_enc_pkg::PAR_BITS,
    parameter logic [PAR_N:0] GEN = bch_enc_pkg::GEN_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic out_is_par,
    output logic out_eob
);

    logic take, clear, par_shift, last_par, par_msb;

    bch_blk_ctrl #(.MSG_N(MSG_N), .PAR_N(PAR_N)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_ready(in_ready), .take(take), .clear(clear),
        .par_shift(par_shift), .last_par(last_par)
    );

    bch_lfsr_div #(.PAR_N(PAR_N), .GEN(GEN)) div_i (
        .clk(clk), .rst_n(rst_n), .take(take), .clear(clear),
        .par_shift(par_shift), .in_bit(in_bit), .par_msb(par_msb)
    );

    bch_out_mux mux_i (
        .take(take), .in_bit(in_bit), .par_shift(par_shift),
        .par_msb(par_msb), .last_par(last_par),
        .out_valid(out_valid), .out_bit(out_bit),
        .out_is_par(out_is_par), .out_eob(out_eob)
    );

endmodule

// File: rtl/bch_sector_enc_chk.sv
module bch_sector_enc_chk #(
    parameter int PAR_N = 91
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_bit,
    input logic in_ready,
    input logic out_valid,
    input logic out_bit,
    input logic out_is_par,
    input logic out_eob
);

    localparam int RUN_W = $clog2(PAR_N + 1);

    logic [RUN_W-1:0] par_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          par_run_q <= '0;
        else if (out_is_par) par_run_q <= par_run_q + 1'b1;
        else                 par_run_q <= '0;
    end

    a_r2_data_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_par) |-> (in_valid && out_bit == in_bit));

    a_r3_parity_always_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_par |-> out_valid);

    a_r5_ready_low_in_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_par |-> !in_ready);

    a_r6_eob_on_last_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_eob |-> (out_is_par && par_run_q == RUN_W'(PAR_N - 1)));

    a_r6_parity_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_par && par_run_q == RUN_W'(PAR_N - 1)) |-> out_eob);

    a_r9_no_output_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !out_is_par) |-> !out_valid);

    a_r10_ready_after_eob: assert property (@(posedge clk) disable iff (!rst_n)
        out_eob |=> (in_ready && !out_is_par));

endmodule

bind bch_sector_enc bch_sector_enc_chk #(.PAR_N(PAR_N)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_is_par(out_is_par), .out_eob(out_eob)
);

// File: tb/bch_sector_enc_tb_top.sv
module bch_sector_enc_tb_top;
    import bch_enc_pkg::*;

    localparam int MSG = bch_enc_pkg::MSG_BITS;
    localparam int PAR = bch_enc_pkg::PAR_BITS;
    localparam int CODE = MSG + PAR;
    localparam logic [PAR:0] G = bch_enc_pkg::GEN_POLY;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_bit = 1'b0;
    logic in_ready, out_valid, out_bit, out_is_par, out_eob;

    int n_checks = 0;
    int n_fails = 0;
    bit done_flag = 1'b0;

    logic  exp_bit_q[$];
    logic  exp_par_q[$];
    logic  exp_eob_q[$];
    string exp_req_q[$];
    logic  rx_q[$];

    always #2 clk = ~clk;

    bch_sector_enc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
        .out_bit(out_bit), .out_is_par(out_is_par), .out_eob(out_eob)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Reference: remainder of w(x) modulo g(x) by long division.
    function automatic logic [PAR-1:0] poly_mod(input logic [CODE-1:0] w);
        logic [CODE-1:0] r;
        r = w;
        for (int d = CODE - 1; d >= PAR; d--) begin
            if (r[d]) r[d -: PAR+1] = r[d -: PAR+1] ^ G;
        end
        return r[PAR-1:0];
    endfunction

    task automatic drive(input logic v, input logic s, input logic b);
        @(posedge clk);
        #1;
        in_valid = v;
        in_sop   = s;
        in_bit   = b;
    endtask

    task automatic push_exp(input logic b, input logic p, input logic e, input string req);
        exp_bit_q.push_back(b);
        exp_par_q.push_back(p);
        exp_eob_q.push_back(e);
        exp_req_q.push_back(req);
    endtask

    // Driver: one full sector, optional stalls, optional junk during parity.
    task automatic send_block(input logic [MSG-1:0] mv, input int gap_pct, input bit junk);
        logic [PAR-1:0] rem;
        for (int i = 0; i < MSG; i++) begin
            if (i > 0) begin
                while (int'($urandom_range(99)) < gap_pct) begin
                    drive(1'b0, 1'b0, 1'($urandom));
                    @(negedge clk);
                    check(out_valid == 1'b0, "R9", "out_valid in stall", int'(out_valid), 0);
                end
            end
            drive(1'b1, i == 0, mv[MSG-1-i]);
            push_exp(mv[MSG-1-i], 1'b0, 1'b0, "R2");
            if (i == 0) begin
                @(negedge clk);
                check(in_ready == 1'b1, "R10", "in_ready at sector start", int'(in_ready), 1);
            end
        end
        rem = poly_mod({mv, {PAR{1'b0}}});
        for (int k = 0; k < PAR; k++) push_exp(rem[PAR-1-k], 1'b1, k == PAR - 1, "R3");
        for (int k = 0; k < PAR; k++) begin
            if (junk) drive(1'($urandom), 1'($urandom), 1'($urandom));
            else      drive(1'b0, 1'b0, 1'b0);
            @(negedge clk);
            check(in_ready == 1'b0, "R5", "in_ready in parity", int'(in_ready), 0);
        end
    endtask

    // Monitor: scoreboard compare and codeword divisibility.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_bit_q.size() == 0) begin
                check(1'b0, "R7", "unexpected out_valid", 1, 0);
            end else begin
                logic  eb, ep, ee;
                string rq;
                eb = exp_bit_q.pop_front();
                ep = exp_par_q.pop_front();
                ee = exp_eob_q.pop_front();
                rq = exp_req_q.pop_front();
                check(out_bit == eb, rq, "out_bit", int'(out_bit), int'(eb));
                check(out_is_par == ep, rq, "out_is_par", int'(out_is_par), int'(ep));
                check(out_eob == ee, "R6", "out_eob", int'(out_eob), int'(ee));
            end
            rx_q.push_back(out_bit);
            if (out_eob) begin
                logic [CODE-1:0] w;
                int base;
                w = '0;
                base = rx_q.size() - CODE;
                if (base >= 0) begin
                    for (int i = 0; i < CODE; i++) w[CODE-1-i] = rx_q[base+i];
                    check(poly_mod(w) == '0, "R4", "codeword remainder nonzero", 1, 0);
                end else begin
                    check(1'b0, "R4", "codeword length", rx_q.size(), CODE);
                end
                rx_q.delete();
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [MSG-1:0] mv;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_is_par == 1'b0, "R1", "out_is_par after reset", int'(out_is_par), 0);
        check(out_eob == 1'b0, "R1", "out_eob after reset", int'(out_eob), 0);

        // R7: non-start beats while idle are dropped.
        for (int k = 0; k < 20; k++) begin
            drive(1'b1, 1'b0, 1'($urandom));
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "out_valid for idle beat", int'(out_valid), 0);
        end

        mv = '0;
        send_block(mv, 0, 1'b0);                       // all zero
        mv = '0; mv[MSG-1] = 1'b1;
        send_block(mv, 0, 1'b1);                       // single first bit, back to back
        mv = '0; mv[0] = 1'b1;
        send_block(mv, 0, 1'b1);                       // single last bit
        mv = '1;
        send_block(mv, 0, 1'b0);                       // all ones

        for (int k = 0; k < 15; k++) begin             // R7 between sectors
            drive(1'b1, 1'b0, 1'($urandom));
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "out_valid for idle beat", int'(out_valid), 0);
        end

        for (int i = 0; i < MSG; i++) mv[i] = 1'($urandom);
        send_block(mv, 30, 1'b1);                      // R9 stalls

        // R8: abandon a sector midway and restart with a marker.
        for (int i = 0; i < 300; i++) begin
            logic b;
            b = 1'($urandom);
            drive(1'b1, i == 0, b);
            push_exp(b, 1'b0, 1'b0, "R8");
        end
        for (int i = 0; i < MSG; i++) mv[i] = 1'($urandom);
        send_block(mv, 0, 1'b1);

        for (int i = 0; i < MSG; i++) mv[i] = 1'($urandom);
        send_block(mv, 5, 1'b1);

        drive(1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(exp_bit_q.size() == 0, "R3", "pending expected outputs", exp_bit_q.size(), 0);
        check(in_ready == 1'b1, "R10", "in_ready when idle", int'(in_ready), 1);
        finish_run();
    end

endmodule